// File: doc/BRIEF.md
# I2C Register Random-Access Sequencer

This block drives a byte-level I2C master engine through complete one-byte transactions with a register-addressed slave, such as a serial memory or a clock chip. A client posts one request: a 7-bit device address, a read/write select, an 8-bit register index and, for writes, one data byte. The block then sends a command to the engine for each step, and it reads the event code that the engine reports after each step. When the transaction ends it raises a one-cycle completion pulse. On that pulse it drops its busy flag and shows the read byte, or an error flag.

A write sends the device address with the write bit, then the register index, then the data byte, then STOP. A read first writes the register index in the same way. It then issues a repeated START, resends the device address with the read bit, receives a single byte that it answers with NACK, and sends STOP.

Each kind of failure has a fixed recovery:
- An address or data NACK in the write phase, or a lost arbitration, gives STOP followed by a fresh START, which retries the whole transaction.
- A NACK on the read address gives only a repeated START.
- Retries are capped by a parameter. When the cap is reached, the transaction ends with the error flag set, so a slave that is absent cannot hang the block.

Top module: `i2c_rra_seq`

## Requirements
- R1: A transmitted address byte holds the device address in bits 7:1 and the direction in bit 0: 0 for write, 1 for read. Device 0x50 therefore gives 0xA0 for a write. Commands on eng_cmd are coded START=0, RSTART=1, TX=2 (byte on eng_tx_byte), RX_NACK=3, STOP=4, STOP_START=5. Events on eng_evt are coded START_DONE=0, RSTART_DONE=1, AW_ACK=2, AW_NACK=3, TXD_ACK=4, TXD_NACK=5, ARB_LOST=6, AR_ACK=7, AR_NACK=8, RXD_NACK=9.
- R2: After START_DONE, the block transmits the address byte with the write bit, whether the request is a read or a write.
- R3: After AW_ACK, the block transmits exactly one byte, the register index.
- R4: In a write, TXD_ACK for the register index leads to TX of the data byte. TXD_ACK for the data byte leads to STOP, a done pulse, busy low and err low.
- R5: In a read, TXD_ACK for the register index leads to RSTART. RSTART_DONE leads to TX of the address byte with the read bit.
- R6: AR_ACK leads to RX_NACK. RXD_NACK leads to STOP, a done pulse with busy low, and rdata equal to eng_rx_byte.
- R7: AW_NACK, TXD_NACK and ARB_LOST each lead to STOP_START, after which the transaction restarts from START_DONE.
- R8: AR_NACK leads to RSTART only, with no STOP.
- R9: A transaction allows MAX_RETRY retries. The next retry-causing event leads to STOP, a done pulse and err high. Accepting a new request clears err and the retry count.
- R10: An event code of 10 to 15, or TXD_ACK while the address byte is pending, leads to STOP, a done pulse and err high.
- R11: A request is accepted only while busy is low, and busy rises on acceptance. Requests made while busy, and events that arrive while idle, have no effect.
- R12: Every command, and busy, done, err and rdata, are registered. Each appears in the cycle after the clock edge that sampled the request or event causing it, and done lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while busy is low |
| req_rd | input | 1 | 1 = random read, 0 = write |
| req_dev | input | 7 | Slave device address |
| req_reg | input | 8 | Register index |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last transaction ended in failure |
| rdata | output | 8 | Byte received by the last read |
| eng_cmd_valid | output | 1 | Command strobe to the byte engine |
| eng_cmd | output | 3 | Command code |
| eng_tx_byte | output | 8 | Byte to transmit with TX |
| eng_evt_valid | input | 1 | Event strobe from the byte engine |
| eng_evt | input | 4 | Event code |
| eng_rx_byte | input | 8 | Byte received by the engine |

## Verification
Every result is due exactly one cycle after the clock edge that samples its cause:
- the START command and busy after a request;
- the next command after an event;
- the STOP command with done, err and rdata after a finishing event.

The bench changes inputs on the falling edge, holds each one for one rising edge, and reads the outputs on the next falling edge. It then checks, on the following falling edge, that done has fallen again. Requests made while the block is busy are checked in the same way: the following address byte must still carry the first device address.

// File: rtl/i2c_rra_pkg.sv
package i2c_rra_pkg;

    // Commands issued to the byte engine
    typedef enum logic [2:0] {
        CMD_START      = 3'd0,
        CMD_RSTART     = 3'd1,
        CMD_TX         = 3'd2,
        CMD_RX_NACK    = 3'd3,
        CMD_STOP       = 3'd4,
        CMD_STOP_START = 3'd5
    } cmd_e;

    // Events reported by the byte engine; codes 10..15 are unexpected
    typedef enum logic [3:0] {
        EV_START_DONE  = 4'd0,
        EV_RSTART_DONE = 4'd1,
        EV_AW_ACK      = 4'd2,
        EV_AW_NACK     = 4'd3,
        EV_TXD_ACK     = 4'd4,
        EV_TXD_NACK    = 4'd5,
        EV_ARB_LOST    = 4'd6,
        EV_AR_ACK      = 4'd7,
        EV_AR_NACK     = 4'd8,
        EV_RXD_NACK    = 4'd9
    } evt_e;

    // Which transmitted byte the next TXD_ACK / address ACK refers to
    typedef enum logic [1:0] {
        STG_ADDR = 2'd0,
        STG_REG  = 2'd1,
        STG_DATA = 2'd2,
        STG_READ = 2'd3
    } stage_e;

endpackage

// File: rtl/i2c_rra_addr.sv
module i2c_rra_addr #(
    parameter int DEV_W  = 7,
    parameter int BYTE_W = 8
) (
    input  logic [DEV_W-1:0]  dev,
    output logic [BYTE_W-1:0] addr_wr,
    output logic [BYTE_W-1:0] addr_rd
);
    localparam int PAD_W = BYTE_W - DEV_W - 1;

    // Device address occupies the upper bits, direction flag the LSB
    generate
        if (PAD_W > 0) begin : g_pad
            assign addr_wr = {{PAD_W{1'b0}}, dev, 1'b0};
            assign addr_rd = {{PAD_W{1'b0}}, dev, 1'b1};
        end else begin : g_nopad
            assign addr_wr = {dev, 1'b0};
            assign addr_rd = {dev, 1'b1};
        end
    endgenerate
endmodule

// File: rtl/i2c_rra_retry.sv
module i2c_rra_retry #(
    parameter int MAX_RETRY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CNT_W = $clog2(MAX_RETRY + 2);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && !at_limit)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_limit = (cnt_q == CNT_W'(MAX_RETRY));

    // R9: the retry count never passes the configured cap
    assert_retry_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_RETRY));
endmodule

// File: rtl/i2c_rra_fsm.sv
module i2c_rra_fsm
    import i2c_rra_pkg::*;
#(
    parameter int DEV_W  = 7,
    parameter int BYTE_W = 8,
    parameter int EVT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_rd,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [BYTE_W-1:0] req_reg,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic              evt_valid,
    input  logic [EVT_W-1:0]  evt,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] addr_wr,
    input  logic [BYTE_W-1:0] addr_rd,
    input  logic              retry_at_limit,
    output logic              retry_clr,
    output logic              retry_inc,
    output logic [DEV_W-1:0]  cur_dev,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [BYTE_W-1:0] rdata,
    output logic              cmd_valid,
    output logic [2:0]        cmd,
    output logic [BYTE_W-1:0] tx_byte
);
    typedef struct packed {
        logic              busy;
        logic              rd;
        logic [DEV_W-1:0]  dev;
        logic [BYTE_W-1:0] reg_a;
        logic [BYTE_W-1:0] wdata;
        stage_e            stage;
        logic              cmd_v;
        cmd_e              cmd;
        logic [BYTE_W-1:0] tx;
        logic              done;
        logic              err;
        logic [BYTE_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cmd_v = 1'b0;
        st_d.done  = 1'b0;
        retry_clr  = 1'b0;
        retry_inc  = 1'b0;

        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy  = 1'b1;
                st_d.rd    = req_rd;
                st_d.dev   = req_dev;
                st_d.reg_a = req_reg;
                st_d.wdata = req_wdata;
                st_d.err   = 1'b0;
                st_d.stage = STG_ADDR;
                st_d.cmd_v = 1'b1;
                st_d.cmd   = CMD_START;
                retry_clr  = 1'b1;
            end
        end else if (evt_valid) begin
            st_d.cmd_v = 1'b1;
            case (evt_e'(evt))
                EV_START_DONE: begin
                    st_d.cmd   = CMD_TX;
                    st_d.tx    = addr_wr;
                    st_d.stage = STG_ADDR;
                end
                EV_RSTART_DONE: begin
                    st_d.cmd   = CMD_TX;
                    st_d.tx    = addr_rd;
                    st_d.stage = STG_READ;
                end
                EV_AW_ACK: begin
                    st_d.cmd   = CMD_TX;
                    st_d.tx    = st_q.reg_a;
                    st_d.stage = STG_REG;
                end
                EV_TXD_ACK: begin
                    if (st_q.stage == STG_REG && st_q.rd) begin
                        st_d.cmd = CMD_RSTART;
                    end else if (st_q.stage == STG_REG) begin
                        st_d.cmd   = CMD_TX;
                        st_d.tx    = st_q.wdata;
                        st_d.stage = STG_DATA;
                    end else begin
                        st_d.cmd  = CMD_STOP;
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                        st_d.err  = (st_q.stage != STG_DATA);
                    end
                end
                EV_AW_NACK, EV_TXD_NACK, EV_ARB_LOST: begin
                    if (retry_at_limit) begin
                        st_d.cmd  = CMD_STOP;
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                        st_d.err  = 1'b1;
                    end else begin
                        st_d.cmd  = CMD_STOP_START;
                        retry_inc = 1'b1;
                    end
                end
                EV_AR_ACK: begin
                    st_d.cmd = CMD_RX_NACK;
                end
                EV_AR_NACK: begin
                    if (retry_at_limit) begin
                        st_d.cmd  = CMD_STOP;
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                        st_d.err  = 1'b1;
                    end else begin
                        st_d.cmd  = CMD_RSTART;
                        retry_inc = 1'b1;
                    end
                end
                EV_RXD_NACK: begin
                    st_d.rdata = rx_byte;
                    st_d.cmd   = CMD_STOP;
                    st_d.busy  = 1'b0;
                    st_d.done  = 1'b1;
                end
                default: begin
                    st_d.cmd  = CMD_STOP;
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    st_d.err  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, rd: 1'b0, dev: '0, reg_a: '0, wdata: '0,
                      stage: STG_ADDR, cmd_v: 1'b0, cmd: CMD_START, tx: '0,
                      done: 1'b0, err: 1'b0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_dev   = st_q.dev;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign err       = st_q.err;
    assign rdata     = st_q.rdata;
    assign cmd_valid = st_q.cmd_v;
    assign cmd       = st_q.cmd;
    assign tx_byte   = st_q.tx;

    // R4 / R6: a command while idle is only ever the final STOP of a completion
    assert_stop_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cmd_v && !st_q.busy) |-> (st_q.done && st_q.cmd == CMD_STOP));

    // R12: completion is a single-cycle pulse
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R11: latched request fields stay put while a transaction runs
    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !evt_valid) |=> ($stable(st_q.dev) && $stable(st_q.reg_a)
                                       && $stable(st_q.wdata) && $stable(st_q.rd)));

    // R2: an address byte sent in the write phase carries direction 0
    assert_write_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cmd_v && st_q.cmd == CMD_TX && st_q.stage == STG_ADDR) |-> !st_q.tx[0]);

    // R5: an address byte sent after the repeated START carries direction 1
    assert_read_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cmd_v && st_q.cmd == CMD_TX && st_q.stage == STG_READ) |-> st_q.tx[0]);

    // R9: the error flag only rises together with completion
    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err) |-> st_q.done);
endmodule

// File: rtl/i2c_rra_seq.sv
module i2c_rra_seq #(
    parameter int DEV_W     = 7,
    parameter int BYTE_W    = 8,
    parameter int EVT_W     = 4,
    parameter int MAX_RETRY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_rd,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [BYTE_W-1:0] req_reg,
    input  logic [BYTE_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [BYTE_W-1:0] rdata,
    output logic              eng_cmd_valid,
    output logic [2:0]        eng_cmd,
    output logic [BYTE_W-1:0] eng_tx_byte,
    input  logic              eng_evt_valid,
    input  logic [EVT_W-1:0]  eng_evt,
    input  logic [BYTE_W-1:0] eng_rx_byte
);
    logic [DEV_W-1:0]  cur_dev;
    logic [BYTE_W-1:0] addr_wr, addr_rd;
    logic              retry_clr, retry_inc, retry_at_limit;

    i2c_rra_addr #(.DEV_W(DEV_W), .BYTE_W(BYTE_W)) u_addr (
        .dev     (cur_dev),
        .addr_wr (addr_wr),
        .addr_rd (addr_rd)
    );

    i2c_rra_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (retry_clr),
        .inc      (retry_inc),
        .at_limit (retry_at_limit)
    );

    i2c_rra_fsm #(.DEV_W(DEV_W), .BYTE_W(BYTE_W), .EVT_W(EVT_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_rd         (req_rd),
        .req_dev        (req_dev),
        .req_reg        (req_reg),
        .req_wdata      (req_wdata),
        .evt_valid      (eng_evt_valid),
        .evt            (eng_evt),
        .rx_byte        (eng_rx_byte),
        .addr_wr        (addr_wr),
        .addr_rd        (addr_rd),
        .retry_at_limit (retry_at_limit),
        .retry_clr      (retry_clr),
        .retry_inc      (retry_inc),
        .cur_dev        (cur_dev),
        .busy           (busy),
        .done           (done),
        .err            (err),
        .rdata          (rdata),
        .cmd_valid      (eng_cmd_valid),
        .cmd            (eng_cmd),
        .tx_byte        (eng_tx_byte)
    );
endmodule

// File: tb/i2c_rra_seq_tb.sv
`timescale 1ns/1ps
module i2c_rra_seq_tb_top;
    localparam int MAXR = 3;
    localparam int C_START = 0, C_RSTART = 1, C_TX = 2, C_RXN = 3, C_STOP = 4, C_SS = 5;
    localparam int E_SD = 0, E_RSD = 1, E_AWA = 2, E_AWN = 3, E_TDA = 4, E_TDN = 5,
                   E_ARB = 6, E_ARA = 7, E_ARN = 8, E_RDN = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_rd = 1'b0;
    logic [6:0] req_dev = '0;
    logic [7:0] req_reg = '0, req_wdata = '0;
    logic       busy, done, err;
    logic [7:0] rdata;
    logic       eng_cmd_valid;
    logic [2:0] eng_cmd;
    logic [7:0] eng_tx_byte;
    logic       eng_evt_valid = 1'b0;
    logic [3:0] eng_evt = '0;
    logic [7:0] eng_rx_byte = '0;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    i2c_rra_seq #(.MAX_RETRY(MAXR)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
        .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd), .eng_tx_byte(eng_tx_byte),
        .eng_evt_valid(eng_evt_valid), .eng_evt(eng_evt), .eng_rx_byte(eng_rx_byte)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Command check at the falling edge after the causing edge
    task automatic exp_cmd(input string req, input int c, input int b);
        chk(eng_cmd_valid == 1'b1, {req, " cmd_valid"}, int'(eng_cmd_valid), 1);
        chk(int'(eng_cmd) == c, {req, " cmd"}, int'(eng_cmd), c);
        if (c == C_TX) chk(int'(eng_tx_byte) == b, {req, " tx_byte"}, int'(eng_tx_byte), b);
    endtask

    task automatic request(input bit rd, input int dev, input int rg, input int wd);
        req_valid = 1'b1; req_rd = rd;
        req_dev = 7'(dev); req_reg = 8'(rg); req_wdata = 8'(wd);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R11 busy on accept", int'(busy), 1);
        chk(err == 1'b0, "R9 err cleared on accept", int'(err), 0);
        exp_cmd("R12 start after request", C_START, 0);
    endtask

    task automatic event_in(input int code, input int rx);
        eng_evt_valid = 1'b1; eng_evt = 4'(code); eng_rx_byte = 8'(rx);
        @(negedge clk);
        eng_evt_valid = 1'b0;
    endtask

    task automatic exp_finish(input string req, input bit e);
        exp_cmd({req, " stop"}, C_STOP, 0);
        chk(done == 1'b1, {req, " done"}, int'(done), 1);
        chk(busy == 1'b0, {req, " busy low"}, int'(busy), 0);
        chk(err == e, {req, " err"}, int'(err), int'(e));
        @(negedge clk);
        chk(done == 1'b0, "R12 done one cycle", int'(done), 0);
        chk(eng_cmd_valid == 1'b0, "R12 no trailing cmd", int'(eng_cmd_valid), 0);
    endtask

    task automatic run_write(input int dev, input int rg, input int wd);
        request(0, dev, rg, wd);
        event_in(E_SD, 0);  exp_cmd("R2 addr+W", C_TX, (dev << 1));
        event_in(E_AWA, 0); exp_cmd("R3 reg index", C_TX, rg);
        event_in(E_TDA, 0); exp_cmd("R4 data byte", C_TX, wd);
        event_in(E_TDA, 0); exp_finish("R4 write end", 0);
    endtask

    task automatic run_read(input int dev, input int rg, input int rx);
        request(1, dev, rg, 0);
        event_in(E_SD, 0);  exp_cmd("R2 read uses addr+W first", C_TX, (dev << 1));
        event_in(E_AWA, 0); exp_cmd("R3 reg index", C_TX, rg);
        event_in(E_TDA, 0); exp_cmd("R5 repeated start", C_RSTART, 0);
        event_in(E_RSD, 0); exp_cmd("R1 R5 addr+R", C_TX, (dev << 1) | 1);
        event_in(E_ARA, 0); exp_cmd("R6 rx with nack", C_RXN, 0);
        event_in(E_RDN, rx); exp_finish("R6 read end", 0);
        chk(int'(rdata) == rx, "R6 rdata", int'(rdata), rx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int devs[4];
        int regs[3];
        devs = '{8'h00, 8'h2A, 8'h50, 8'h7F};
        regs = '{8'h00, 8'h5A, 8'hFF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0, "R12 reset busy", int'(busy), 0);
        chk(done == 0, "R12 reset done", int'(done), 0);
        chk(err == 0, "R12 reset err", int'(err), 0);
        chk(eng_cmd_valid == 0, "R12 reset cmd_valid", int'(eng_cmd_valid), 0);
        chk(rdata == 0, "R12 reset rdata", int'(rdata), 0);

        // R11: events while idle do nothing
        event_in(E_AWA, 0);
        chk(eng_cmd_valid == 0, "R11 idle event ignored", int'(eng_cmd_valid), 0);
        chk(busy == 0, "R11 idle event busy", int'(busy), 0);

        // R1 device 0x50 write address is 0xA0
        request(0, 8'h50, 8'h04, 8'h11);
        event_in(E_SD, 0); exp_cmd("R1 0x50 gives 0xA0", C_TX, 8'hA0);
        event_in(E_AWA, 0); exp_cmd("R3 reg", C_TX, 8'h04);
        event_in(E_TDA, 0); exp_cmd("R4 data", C_TX, 8'h11);
        event_in(E_TDA, 0); exp_finish("R4 end", 0);

        // Sweep over device and register values
        foreach (devs[i]) foreach (regs[j]) begin
            run_write(devs[i], regs[j], (devs[i] ^ regs[j]) & 8'hFF);
            run_read(devs[i], regs[j], (~(devs[i] + regs[j])) & 8'hFF);
        end

        // R7: each write-phase failure gives STOP_START then a full restart
        for (int k = 0; k < 3; k++) begin
            request(0, 8'h33, 8'h21, 8'h7E);
            event_in(E_SD, 0); exp_cmd("R2", C_TX, 8'h66);
            if (k == 0) begin
                event_in(E_AWN, 0); exp_cmd("R7 aw nack", C_SS, 0);
            end else if (k == 1) begin
                event_in(E_AWA, 0); exp_cmd("R3", C_TX, 8'h21);
                event_in(E_TDA, 0); exp_cmd("R4", C_TX, 8'h7E);
                event_in(E_TDN, 0); exp_cmd("R7 data nack", C_SS, 0);
            end else begin
                event_in(E_ARB, 0); exp_cmd("R7 arb lost", C_SS, 0);
            end
            chk(busy == 1, "R7 busy kept", int'(busy), 1);
            event_in(E_SD, 0); exp_cmd("R7 restart addr+W", C_TX, 8'h66);
            event_in(E_AWA, 0); exp_cmd("R7 restart reg", C_TX, 8'h21);
            event_in(E_TDA, 0); exp_cmd("R7 restart data", C_TX, 8'h7E);
            event_in(E_TDA, 0); exp_finish("R7 end", 0);
        end

        // R8: read-address NACK gives a repeated START only
        request(1, 8'h68, 8'h02, 0);
        event_in(E_SD, 0); event_in(E_AWA, 0); event_in(E_TDA, 0);
        event_in(E_RSD, 0); exp_cmd("R5 addr+R", C_TX, 8'hD1);
        event_in(E_ARN, 0); exp_cmd("R8 rstart only", C_RSTART, 0);
        event_in(E_RSD, 0); exp_cmd("R8 addr+R again", C_TX, 8'hD1);
        event_in(E_ARA, 0); exp_cmd("R6", C_RXN, 0);
        event_in(E_RDN, 8'h59); exp_finish("R8 end", 0);
        chk(rdata == 8'h59, "R8 rdata", int'(rdata), 8'h59);

        // R9: cap reached, then the counter restarts per request
        for (int t = 0; t < 2; t++) begin
            request(0, 8'h10, 8'h00, 8'h00);
            for (int n = 0; n < MAXR; n++) begin
                event_in(t == 0 ? E_AWN : E_ARN, 0);
                exp_cmd("R9 retry within cap", t == 0 ? C_SS : C_RSTART, 0);
            end
            event_in(t == 0 ? E_TDN : E_ARN, 0);
            exp_finish("R9 cap exceeded", 1);
        end

        // R10: unexpected codes and TXD_ACK while the address is pending
        for (int u = 10; u < 16; u++) begin
            request(u[0], u, u, 0);
            event_in(u, 0); exp_finish("R10 unexpected code", 1);
        end
        request(0, 8'h05, 8'h06, 8'h07);
        event_in(E_SD, 0);
        event_in(E_TDA, 0); exp_finish("R10 ack in address stage", 1);

        // R11: a request while busy is ignored
        request(0, 8'h12, 8'h34, 8'h56);
        req_valid = 1'b1; req_dev = 7'h6B; req_reg = 8'h99; req_wdata = 8'hAA; req_rd = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(eng_cmd_valid == 0, "R11 busy request no cmd", int'(eng_cmd_valid), 0);
        event_in(E_SD, 0); exp_cmd("R11 first dev kept", C_TX, 8'h24);
        event_in(E_AWA, 0); exp_cmd("R11 first reg kept", C_TX, 8'h34);
        event_in(E_TDA, 0); exp_cmd("R11 first write kept", C_TX, 8'h56);
        event_in(E_TDA, 0); exp_finish("R11 end", 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule